// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This unit sits beside the integer pipeline of a 32-bit processor. It performs the eight multiply, divide and remainder operations of the standard integer multiply extension, one bit per clock. The caller presents two operands and a 3-bit operation code, then pulses `start`. The unit raises `busy` and works through one setup cycle and 32 iteration cycles. It then returns a single 32-bit result together with a one-cycle `done` pulse.

Both operands are first turned into unsigned magnitudes, as each operation's signedness requires. The iteration is either a shift-add multiply or a restoring shift-subtract divide, and both run on the same set of registers. When the last step completes, the result is negated if its sign calls for it. Division by zero and signed overflow produce fixed values and never trap.

The handshake gives back-pressure through `busy` alone. A request is taken only on a clock edge where `start` is high and `busy` is low, and anything presented while `busy` is high is dropped. The result has no back-pressure. It stays on `result` from its `done` pulse until the next `done` pulse.

Top module: `imd_unit`

## Requirements
- R1: Operation code 0 returns bits 31:0 of the product of `opa` and `opb`, and the result is the same whether the operands are read as signed or unsigned.
- R2: Operation code 1 returns bits 63:32 of the 64-bit product of the two operands, both taken as signed.
- R3: Operation code 2 returns bits 63:32 of the 64-bit product of `opa` taken as signed and `opb` taken as unsigned.
- R4: Operation code 3 returns bits 63:32 of the 64-bit product of the two operands, both taken as unsigned.
- R5: Operation code 4 (signed) and code 5 (unsigned) return the quotient `opa / opb`, and a signed quotient is truncated toward zero.
- R6: Operation code 6 (signed) and code 7 (unsigned) return the remainder, and a signed remainder takes the sign of `opa`, so that quotient times divisor plus remainder equals the dividend.
- R7: Codes 4 and 5 with `opb` = 0 return 0xFFFFFFFF, whatever the sign of `opa`.
- R8: Codes 6 and 7 with `opb` = 0 return `opa` unchanged.
- R9: Code 4 with `opa` = 0x80000000 and `opb` = 0xFFFFFFFF returns 0x80000000, and code 6 with the same operands returns 0.
- R10: A request is accepted on a rising edge with `start` high and `busy` low. `busy` is high for the 33 cycles that follow that edge. `done` is high for exactly one cycle, beginning 33 edges after the accepting edge, with `busy` low in that cycle.
- R11: While `busy` is high, `start`, `op`, `opa` and `opb` have no effect on the current result or on later results. `result` changes only in a cycle where `done` is high.
- R12: While `rst_n` is low, `busy` and `done` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while `busy` is low |
| op | input | 3 | Operation code 0..7, sampled with `start` |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress; requests are dropped |
| done | output | 1 | One-cycle pulse marking a new `result` |
| result | output | 32 | Result of the last completed operation |

## Verification
The bench targets the signed extremes. These are 0x80000000 as a multiplier factor, as a dividend and as the overflow dividend, with divisors of 0, 1 and all ones. A wrong magnitude or sign-correction stage returns a value off by one or with the wrong sign for these operands. Zero divisors with a negative dividend expose a design that applies the quotient sign fix to the all-ones result and returns 1. Mixed-sign high multiplies expose a design that extends `opb` as signed. Garbage requests sent while busy, and a `start` held high across completion, expose a design that latches the new operands mid-operation, or that misses or double-counts the back-to-back acceptance edge.

// File: rtl/imd_pkg.sv
package imd_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } imd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } imd_state_e;

  // Divide family occupies codes 4..7.
  function automatic logic op_is_div(imd_op_e o);
    return o[2];
  endfunction

  // First operand carries a sign.
  function automatic logic op_a_signed(imd_op_e o);
    return (o == OP_MULH) || (o == OP_MULHSU) || (o == OP_DIV) || (o == OP_REM);
  endfunction

  // Second operand carries a sign.
  function automatic logic op_b_signed(imd_op_e o);
    return (o == OP_MULH) || (o == OP_DIV) || (o == OP_REM);
  endfunction

endpackage

// File: rtl/imd_prep.sv
// Converts the raw operands into magnitudes and records the sign fixes to
// apply once the iteration finishes.
module imd_prep
  import imd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  imd_op_e           op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   mag_a,
  output logic [XLEN-1:0]   mag_b,
  output logic              neg_main,
  output logic              neg_rem
);
  logic sa, sb, b_zero;

  always_comb begin
    sa       = op_a_signed(op) & a[XLEN-1];
    sb       = op_b_signed(op) & b[XLEN-1];
    b_zero   = (b == '0);
    mag_a    = sa ? (~a + 1'b1) : a;
    mag_b    = sb ? (~b + 1'b1) : b;
    // A zero divisor leaves an all-ones quotient that must stay unsigned.
    neg_main = op_is_div(op) ? ((sa ^ sb) & ~b_zero) : (sa ^ sb);
    neg_rem  = op_is_div(op) & sa;
  end
endmodule

// File: rtl/imd_mul_step.sv
// One shift-add multiply step: {hi,lo} holds partial product and multiplier.
module imd_mul_step #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] mcand,
  output logic [XLEN-1:0] nx_hi,
  output logic [XLEN-1:0] nx_lo
);
  logic [XLEN:0] sum;

  always_comb begin
    sum   = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
    nx_hi = sum[XLEN:1];
    nx_lo = {sum[0], lo[XLEN-1:1]};
  end
endmodule

// File: rtl/imd_div_step.sv
// One restoring divide step: hi is the partial remainder, lo shifts the
// dividend out at the top and the quotient in at the bottom.
module imd_div_step #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] dvsr,
  output logic [XLEN-1:0] nx_hi,
  output logic [XLEN-1:0] nx_lo
);
  logic [XLEN:0]   rem_sh;
  logic [XLEN-1:0] diff;
  logic            fits;

  always_comb begin
    rem_sh = {hi, lo[XLEN-1]};
    fits   = (rem_sh >= {1'b0, dvsr});
    diff   = rem_sh[XLEN-1:0] - dvsr;
    nx_hi  = fits ? diff : rem_sh[XLEN-1:0];
    nx_lo  = {lo[XLEN-2:0], fits};
  end
endmodule

// File: rtl/imd_fixup.sv
// Applies the deferred sign corrections and selects the returned half.
module imd_fixup
  import imd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  imd_op_e           op,
  input  logic              neg_main,
  input  logic              neg_rem,
  input  logic [XLEN-1:0]   hi,
  input  logic [XLEN-1:0]   lo,
  output logic [XLEN-1:0]   res
);
  localparam int PW = 2 * XLEN;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] quo, rmd;

  always_comb begin
    prod = neg_main ? (~{hi, lo} + 1'b1) : {hi, lo};
    quo  = neg_main ? (~lo + 1'b1) : lo;
    rmd  = neg_rem  ? (~hi + 1'b1) : hi;
    unique case (op)
      OP_MUL:                       res = prod[XLEN-1:0];
      OP_MULH, OP_MULHSU, OP_MULHU: res = prod[PW-1:XLEN];
      OP_DIV, OP_DIVU:              res = quo;
      default:                      res = rmd;
    endcase
  end
endmodule

// File: rtl/imd_unit.sv
module imd_unit
  import imd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  imd_state_e      state_q;
  imd_op_e         op_q;
  logic [XLEN-1:0] hi_q, lo_q, dv_q, res_q;
  logic [CW-1:0]   cnt_q;
  logic            neg_main_q, neg_rem_q, done_q;

  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_main_d, neg_rem_d;
  logic [XLEN-1:0] m_hi, m_lo, d_hi, d_lo, s_hi, s_lo, fix_res;

  imd_prep #(.XLEN(XLEN)) prep_i (
    .op(op_q), .a(lo_q), .b(dv_q),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_main(neg_main_d), .neg_rem(neg_rem_d)
  );

  imd_mul_step #(.XLEN(XLEN)) mul_i (
    .hi(hi_q), .lo(lo_q), .mcand(dv_q), .nx_hi(m_hi), .nx_lo(m_lo)
  );

  imd_div_step #(.XLEN(XLEN)) div_i (
    .hi(hi_q), .lo(lo_q), .dvsr(dv_q), .nx_hi(d_hi), .nx_lo(d_lo)
  );

  always_comb begin
    s_hi = op_is_div(op_q) ? d_hi : m_hi;
    s_lo = op_is_div(op_q) ? d_lo : m_lo;
  end

  imd_fixup #(.XLEN(XLEN)) fix_i (
    .op(op_q), .neg_main(neg_main_q), .neg_rem(neg_rem_q),
    .hi(s_hi), .lo(s_lo), .res(fix_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_MUL;
      hi_q       <= '0;
      lo_q       <= '0;
      dv_q       <= '0;
      cnt_q      <= '0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      done_q     <= 1'b0;
      res_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= imd_op_e'(op);
            lo_q    <= opa;
            dv_q    <= opb;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          hi_q       <= '0;
          lo_q       <= mag_a;
          dv_q       <= mag_b;
          neg_main_q <= neg_main_d;
          neg_rem_q  <= neg_rem_d;
          cnt_q      <= '0;
          state_q    <= ST_RUN;
        end
        ST_RUN: begin
          hi_q  <= s_hi;
          lo_q  <= s_lo;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            res_q   <= fix_res;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/imd_unit_chk.sv
module imd_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [2:0]      op,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  localparam int LAT = XLEN + 1;
  localparam int LW  = $clog2(LAT + 2);
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

  logic [LW-1:0]   lat_q;
  logic [2:0]      cap_op;
  logic [XLEN-1:0] cap_a, cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      cap_op <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
    end else if (start && !busy) begin
      lat_q  <= '0;
      cap_op <= op;
      cap_a  <= opa;
      cap_b  <= opb;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && lat_q == LW'(LAT)));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_mul_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == 3'd0) |-> (result == XLEN'(cap_a * cap_b)));

  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[2:1] == 2'b10 && cap_b == '0) |-> (result == '1));

  p_rem_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op[2:1] == 2'b11 && cap_b == '0) |-> (result == cap_a));

  p_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_op == 3'd4 && cap_a == MINV && cap_b == '1) |-> (result == MINV));
endmodule

bind imd_unit imd_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
  .busy(busy), .done(done), .result(result)
);

// File: tb/imd_unit_tb_top.sv
module imd_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        busy, done;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] rng = 32'h1234_5678;

  // Reference model state
  logic        m_busy = 1'b0;
  logic        m_done = 1'b0;
  logic [31:0] m_res = '0;
  logic [31:0] m_pend = '0;
  string       m_tag = "R12";
  string       m_pend_tag = "R12";
  int          m_cnt = 0;

  always #5 clk = ~clk;

  imd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] ref_calc(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ub = longint'({32'h0, b});
    longint unsigned ua = {32'h0, a};
    longint unsigned uu = {32'h0, b};
    longint p;
    longint unsigned pu;
    int ia = $signed(a);
    int ib = $signed(b);
    case (o)
      3'd0: begin pu = ua * uu; return pu[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin pu = ua * uu; return pu[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'(ia / ib);
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
        return 32'(ia % ib);
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o, logic [31:0] a, logic [31:0] b);
    if (o[2] && b == 0) return o[1] ? "R8" : "R7";
    if ((o == 3'd4 || o == 3'd6) && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R9";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Cycle model: R10 timing, R11 input masking while busy, R12 reset.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_cnt = 0; m_tag = "R12";
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 33) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = m_pend; m_tag = m_pend_tag;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0;
        m_pend = ref_calc(op, opa, opb);
        m_pend_tag = req_of(op, opa, opb);
      end
    end
  end

  always @(negedge clk) begin
    string tag;
    n_cmp = n_cmp + 1;
    if (!rst_n) tag = "R12";
    else if (m_done || done) tag = m_tag;
    else if (busy !== m_busy) tag = "R10";
    else tag = "R11";
    if (busy !== m_busy || done !== m_done || result !== m_res) begin
      n_bad = n_bad + 1;
      $display("FAIL %s at cycle %0d: busy %b exp %b, done %b exp %b, result %h exp %h",
               tag, cyc, busy, m_busy, done, m_done, result, m_res);
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL R10 watchdog expired: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Issue one request; with noise, throw ignored requests while busy (R11).
  task automatic issue(input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, input bit noise);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = noise;
    for (int i = 0; i < 20 && noise; i++) begin
      rng = next_rng(rng);
      op = rng[2:0]; opa = rng; opb = {rng[15:0], rng[31:16]};
      @(negedge clk);
    end
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    issue(3'd0, 32'd3, 32'd5, 1'b0);
    issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    // R2
    issue(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    issue(3'd1, 32'hFFFF_FFFF, 32'd1, 1'b0);
    // R3
    issue(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    issue(3'd2, 32'd2, 32'hFFFF_FFFF, 1'b1);
    // R4
    issue(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    // R5 and R6
    issue(3'd4, 32'hFFFF_FFF9, 32'd2, 1'b0);
    issue(3'd6, 32'hFFFF_FFF9, 32'd2, 1'b0);
    issue(3'd6, 32'd7, 32'hFFFF_FFFE, 1'b0);
    issue(3'd5, 32'hFFFF_FFFF, 32'd1, 1'b0);
    issue(3'd7, 32'hFFFF_FFFF, 32'd10, 1'b1);
    // R7 and R8
    issue(3'd5, 32'd7, 32'd0, 1'b0);
    issue(3'd4, 32'hFFFF_FFF9, 32'd0, 1'b0);
    issue(3'd6, 32'hFFFF_FFF9, 32'd0, 1'b0);
    issue(3'd7, 32'd5, 32'd0, 1'b0);
    // R9
    issue(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    issue(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    issue(3'd4, 32'h8000_0000, 32'd1, 1'b0);
    // R10: start held high across completion, accepted right after done
    @(negedge clk);
    start = 1'b1; op = 3'd1; opa = 32'h1234_5678; opb = 32'h9ABC_DEF0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      while (!done) @(negedge clk);
      op = 3'(k + 4); opa = 32'h8765_4321 + 32'(k); opb = 32'(k * 3);
    end
    start = 1'b0;
    while (busy) @(negedge clk);
    // Pseudo-random sweep over all operation codes
    for (int n = 0; n < 160; n++) begin
      logic [31:0] a, b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      if (n % 9 == 0) b = 32'h0;
      if (n % 11 == 0) b = 32'hFFFF_FFFF;
      if (n % 13 == 0) a = 32'h8000_0000;
      if (n % 7 == 0) b = {28'h0, b[3:0]};
      issue(3'(n % 8), a, b, (n % 5) == 0);
    end
    // R12: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; op = 3'd3; opa = 32'hDEAD_BEEF; opb = 32'hCAFE_F00D;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    issue(3'd0, 32'd6, 32'd7, 1'b0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule